// File: doc/BRIEF.md
# Clock and Shared-Pin Enable Controller

This block sits between the clock configuration inputs and the clock oscillators. It holds a small two-bit control register. One bit switches the internal clock generator on, the other switches the external clock generator on. The block turns these bits, together with a stop-mode level from the system controller, into generator enables and a global stop indication. It gates the three generated clocks low whenever their enable is off: the internal clock, the low-frequency base clock and the external clock.

The two oscillator pins double as general-purpose port pins. The block drives a port-function enable for each pin. A pin is handed back to the port logic only when the oscillator does not need it. These pin enables deliberately ignore stop mode, so a pin that the oscillator has claimed stays claimed while stopped. A configuration input locks out any attempt to switch the external generator on.

The gating uses no latches. Each enable is retimed on the falling edge of the clock it gates before it is ANDed in. As a result, a gated output never produces a shortened pulse when its enable changes.

Top module: `clkpin_enable_top`

## Requirements
- R1: After reset, the control register reads back `2'b01`, with bit 0 = internal-on set and bit 1 = external-on clear.
- R2: `stop_all` is high exactly when `stop_req` is high and `cfg_keep_in_stop` is low.
- R3: `int_gen_en` equals internal-on AND NOT `stop_all`.
- R4: `ext_gen_en` equals external-on AND NOT `stop_all`.
- R5: Bit 0 of a write always loads internal-on. A write of 0 to bit 1 clears external-on. A write of 1 to bit 1 sets external-on only if `cfg_ext_allow` is high; otherwise external-on keeps its previous value.
- R6: `pin1_port_en` equals NOT external-on, independent of `stop_req`.
- R7: `pin2_port_en` is low only when external-on and `cfg_xtal_allow` are both high, independent of `stop_req`.
- R8: `int_clk_out` and `base_clk_out` stay low while `int_gen_en` is low, and toggle with their raw clocks while it is high.
- R9: `ext_clk_out` stays low while `ext_gen_en` is low, and toggles with its raw clock while it is high.
- R10: Every high pulse on a gated clock output lasts exactly one full high phase of its raw clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register/bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop-mode level from system controller |
| cfg_keep_in_stop | input | 1 | Keep clocks running in stop mode |
| cfg_ext_allow | input | 1 | Permits setting the external-on bit |
| cfg_xtal_allow | input | 1 | Two-pin crystal use of the second pin |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 2 | Write data, bit 0 internal-on, bit 1 external-on |
| rd_data | output | 2 | Control register readback |
| int_clk_raw | input | 1 | Raw internal generator clock |
| base_clk_raw | input | 1 | Raw low-frequency base clock |
| ext_clk_raw | input | 1 | Raw external generator clock |
| stop_all | output | 1 | Global clock stop |
| int_gen_en | output | 1 | Internal generator enable |
| ext_gen_en | output | 1 | External generator enable |
| int_clk_out | output | 1 | Gated internal clock |
| base_clk_out | output | 1 | Gated base clock |
| ext_clk_out | output | 1 | Gated external clock |
| pin1_port_en | output | 1 | Port enable, first oscillator pin |
| pin2_port_en | output | 1 | Port enable, second oscillator pin |

## Verification
The assertions check the following on every bus clock cycle: the stop decode, the suppression of both generator enables under stop, the write lock on the external-on bit, the unconditional clear, and the independence of the pin enables from stop. Only the bench's scenarios show that the gated clocks really go quiet, or keep running, for each combination of stop, stay-on and register contents. They also show that every pulse leaving the gates has the full width of the raw high phase. The bench sweeps every combination of the configuration inputs, starting register value and write value.

// File: rtl/clkpin_pkg.sv
package clkpin_pkg;
   localparam int LANE_INT  = 0;
   localparam int LANE_BASE = 1;
   localparam int LANE_EXT  = 2;
   localparam int NUM_LANES = 3;

   typedef struct packed {
      logic keep_in_stop;
      logic ext_allow;
      logic xtal_allow;
   } clk_cfg_t;

   typedef struct packed {
      logic stop_all;
      logic int_en;
      logic ext_en;
      logic pin1_en;
      logic pin2_en;
   } clk_ctl_t;
endpackage

// File: rtl/clkpin_ctrl_reg.sv
module clkpin_ctrl_reg #(
   parameter int CTRL_W  = 2,
   parameter int INT_BIT = 0,
   parameter int EXT_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              ext_allow,
   output logic [CTRL_W-1:0] ctrl_q
);
   localparam logic [CTRL_W-1:0] RST_VAL = CTRL_W'(1) << INT_BIT;

   initial begin
      if (INT_BIT == EXT_BIT) $error("control bit positions collide");
      if (INT_BIT >= CTRL_W || EXT_BIT >= CTRL_W) $error("control bit outside register");
   end

   logic [CTRL_W-1:0] ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_en) begin
         ctrl_d[INT_BIT] = wr_data[INT_BIT];
         if (!wr_data[EXT_BIT])
            ctrl_d[EXT_BIT] = 1'b0;
         else if (ext_allow)
            ctrl_d[EXT_BIT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= RST_VAL;
      else        ctrl_q <= ctrl_d;
   end

   // R5
   ext_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[EXT_BIT] && !ext_allow && !ctrl_q[EXT_BIT]) |=> !ctrl_q[EXT_BIT]);

   // R5
   ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[EXT_BIT]) |=> !ctrl_q[EXT_BIT]);

   // R5
   int_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl_q[INT_BIT] == $past(wr_data[INT_BIT])));
endmodule

// File: rtl/clkpin_enable_logic.sv
module clkpin_enable_logic
   import clkpin_pkg::*;
(
   input  logic     stop_req,
   input  clk_cfg_t cfg,
   input  logic     int_on,
   input  logic     ext_on,
   output clk_ctl_t ctl
);
   logic stop_w;

   always_comb begin
      stop_w      = stop_req & ~cfg.keep_in_stop;
      ctl.stop_all = stop_w;
      ctl.int_en   = int_on & ~stop_w;
      ctl.ext_en   = ext_on & ~stop_w;
      ctl.pin1_en  = ~ext_on;
      ctl.pin2_en  = ~(ext_on & cfg.xtal_allow);
   end
endmodule

// File: rtl/clkpin_gate.sv
module clkpin_gate #(
   parameter bit RETIME = 1'b1
) (
   input  logic clk_raw,
   input  logic rst_n,
   input  logic en,
   output logic clk_out
);
   initial begin
      if (RETIME !== 1'b1 && RETIME !== 1'b0) $error("RETIME must be 0 or 1");
   end

   generate
      if (RETIME) begin : g_retimed
         logic en_q;
         always_ff @(negedge clk_raw or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en;
         end
         assign clk_out = clk_raw & en_q;
      end else begin : g_plain
         assign clk_out = clk_raw & en;
      end
   endgenerate
endmodule

// File: rtl/clkpin_enable_top.sv
module clkpin_enable_top
   import clkpin_pkg::*;
#(
   parameter int CTRL_W      = 2,
   parameter int INT_BIT     = 0,
   parameter int EXT_BIT     = 1,
   parameter bit GATE_RETIME = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req,
   input  logic              cfg_keep_in_stop,
   input  logic              cfg_ext_allow,
   input  logic              cfg_xtal_allow,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   input  logic              int_clk_raw,
   input  logic              base_clk_raw,
   input  logic              ext_clk_raw,
   output logic              stop_all,
   output logic              int_gen_en,
   output logic              ext_gen_en,
   output logic              int_clk_out,
   output logic              base_clk_out,
   output logic              ext_clk_out,
   output logic              pin1_port_en,
   output logic              pin2_port_en
);
   logic [CTRL_W-1:0]    ctrl_q;
   clk_cfg_t             cfg;
   clk_ctl_t             ctl;
   logic [NUM_LANES-1:0] raw_vec, en_vec, gated_vec;

   assign cfg = '{keep_in_stop: cfg_keep_in_stop,
                  ext_allow:    cfg_ext_allow,
                  xtal_allow:   cfg_xtal_allow};

   clkpin_ctrl_reg #(.CTRL_W(CTRL_W), .INT_BIT(INT_BIT), .EXT_BIT(EXT_BIT)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .ext_allow (cfg_ext_allow),
      .ctrl_q    (ctrl_q)
   );

   clkpin_enable_logic u_dec (
      .stop_req (stop_req),
      .cfg      (cfg),
      .int_on   (ctrl_q[INT_BIT]),
      .ext_on   (ctrl_q[EXT_BIT]),
      .ctl      (ctl)
   );

   assign raw_vec[LANE_INT]  = int_clk_raw;
   assign raw_vec[LANE_BASE] = base_clk_raw;
   assign raw_vec[LANE_EXT]  = ext_clk_raw;
   assign en_vec[LANE_INT]   = ctl.int_en;
   assign en_vec[LANE_BASE]  = ctl.int_en;
   assign en_vec[LANE_EXT]   = ctl.ext_en;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      clkpin_gate #(.RETIME(GATE_RETIME)) u_gate (
         .clk_raw (raw_vec[i]),
         .rst_n   (rst_n),
         .en      (en_vec[i]),
         .clk_out (gated_vec[i])
      );
   end

   assign rd_data      = ctrl_q;
   assign stop_all     = ctl.stop_all;
   assign int_gen_en   = ctl.int_en;
   assign ext_gen_en   = ctl.ext_en;
   assign pin1_port_en = ctl.pin1_en;
   assign pin2_port_en = ctl.pin2_en;
   assign int_clk_out  = gated_vec[LANE_INT];
   assign base_clk_out = gated_vec[LANE_BASE];
   assign ext_clk_out  = gated_vec[LANE_EXT];

   // R2
   stop_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !cfg_keep_in_stop) |-> stop_all);

   // R3
   stop_kills_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_all |-> !int_gen_en);

   // R4
   stop_kills_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_all |-> !ext_gen_en);

   // R6
   pin1_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[EXT_BIT] |-> !pin1_port_en);

   // R7
   pin2_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_xtal_allow |-> pin2_port_en);
endmodule

// File: tb/tb_clkpin_enable_top.sv
`timescale 1ns/1ps
module tb_clkpin_enable_top;
   logic clk = 0, rst_n = 0;
   logic stop_req = 0, cfg_keep_in_stop = 0, cfg_ext_allow = 0, cfg_xtal_allow = 0;
   logic wr_en = 0;
   logic [1:0] wr_data = 0, rd_data;
   logic int_clk_raw = 0, base_clk_raw = 0, ext_clk_raw = 0;
   logic stop_all, int_gen_en, ext_gen_en, int_clk_out, base_clk_out, ext_clk_out;
   logic pin1_port_en, pin2_port_en;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5  clk = ~clk;
   always #8  int_clk_raw = ~int_clk_raw;
   always #25 base_clk_raw = ~base_clk_raw;
   always #11 ext_clk_raw = ~ext_clk_raw;

   clkpin_enable_top dut (.*);

   int cnt_int = 0, cnt_base = 0, cnt_ext = 0;
   int short_int = 0, short_base = 0, short_ext = 0;
   realtime r_int, r_base, r_ext;

   always @(posedge int_clk_out)  begin cnt_int++;  r_int = $realtime;  end
   always @(posedge base_clk_out) begin cnt_base++; r_base = $realtime; end
   always @(posedge ext_clk_out)  begin cnt_ext++;  r_ext = $realtime;  end
   always @(negedge int_clk_out)  if (rst_n && ($realtime - r_int) != 8.0)   short_int++;
   always @(negedge base_clk_out) if (rst_n && ($realtime - r_base) != 25.0) short_base++;
   always @(negedge ext_clk_out)  if (rst_n && ($realtime - r_ext) != 11.0)  short_ext++;

   task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic chk_cnt(string req, string what, int act, bit expect_run);
      n_chk++;
      if ((act > 0) != expect_run) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d edges expected=%s", req, what, act,
                  expect_run ? "running" : "none");
      end
   endtask

   task automatic do_write(logic [1:0] v);
      @(negedge clk); wr_en = 1; wr_data = v;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic clock_case(string tag, bit exp_int, bit exp_ext);
      #100;
      cnt_int = 0; cnt_base = 0; cnt_ext = 0;
      #300;
      chk_cnt("R8", {tag, " int"},  cnt_int,  exp_int);
      chk_cnt("R8", {tag, " base"}, cnt_base, exp_int);
      chk_cnt("R9", {tag, " ext"},  cnt_ext,  exp_ext);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #23 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "reset readback", rd_data, 2'b01);
      chk("R3", "reset int enable", {1'b0, int_gen_en}, 2'b01);
      chk("R6", "reset pin1", {1'b0, pin1_port_en}, 2'b01);

      for (int c = 0; c < 16; c++) begin
         for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) begin
               logic st, kp, ea, xa, m_int, m_ext, m_stop;
               {st, kp, ea, xa} = 4'(c);
               @(negedge clk);
               stop_req = 0; cfg_ext_allow = 1;
               do_write(2'(s));
               stop_req = st; cfg_keep_in_stop = kp; cfg_ext_allow = ea; cfg_xtal_allow = xa;
               do_write(2'(w));
               m_int  = w[0];
               m_ext  = w[1] ? (ea ? 1'b1 : s[1]) : 1'b0;
               m_stop = st & ~kp;
               chk("R5", "readback", rd_data, {m_ext, m_int});
               chk("R2", "stop_all", {1'b0, stop_all}, {1'b0, m_stop});
               chk("R3", "int_gen_en", {1'b0, int_gen_en}, {1'b0, m_int & ~m_stop});
               chk("R4", "ext_gen_en", {1'b0, ext_gen_en}, {1'b0, m_ext & ~m_stop});
               chk("R6", "pin1_port_en", {1'b0, pin1_port_en}, {1'b0, ~m_ext});
               chk("R7", "pin2_port_en", {1'b0, pin2_port_en}, {1'b0, ~(m_ext & xa)});
            end
         end
      end

      // gated clock scenarios
      stop_req = 0; cfg_keep_in_stop = 0; cfg_ext_allow = 1; cfg_xtal_allow = 1;
      do_write(2'b11);
      clock_case("all on", 1, 1);
      stop_req = 1;
      clock_case("stop", 0, 0);
      chk("R6", "pin1 in stop", {1'b0, pin1_port_en}, 2'b00);
      chk("R7", "pin2 in stop", {1'b0, pin2_port_en}, 2'b00);
      cfg_keep_in_stop = 1;
      clock_case("stop kept", 1, 1);
      stop_req = 0; cfg_keep_in_stop = 0;
      do_write(2'b01);
      clock_case("int only", 1, 0);
      do_write(2'b10);
      clock_case("ext only", 0, 1);
      do_write(2'b00);
      clock_case("none", 0, 0);
      do_write(2'b11);
      clock_case("back on", 1, 1);

      // R10 pulse widths across all the enable changes above
      chk_cnt("R10", "short int pulses",  short_int,  0);
      chk_cnt("R10", "short base pulses", short_base, 0);
      chk_cnt("R10", "short ext pulses",  short_ext,  0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule